// File: doc/BRIEF.md
# In-order multi-issue dependence checker

This block is the issue gate of an in-order superscalar decode stage. Each cycle it looks at a window of up to `WIDTH` decoded instructions in program order and decides how many leading ones may leave together. An instruction is held back when it reads a register written by an older instruction in the same window. It is also held when it reads the destination of a load that issued in the previous cycle. Finally, it is held when it would be a second memory access or a second user of the single divider in the same cycle. Once one slot is held, every younger slot is held with it.

Slots that are held are kept inside the block and moved to the front of the window. They are presented again in the next cycle. The upstream decode stage offers a new group only while `in_ready_o` is high. Each issued slot carries an opaque tag that downstream logic uses to find the instruction. A synchronous flush drops the held slots and forgets any pending load result.

Top module: `iss_gate`

## Requirements
- R1: With no hazards, every valid slot of the window issues in one cycle. Issue lane k of `iss_tag_o` (bits k*8 up to k*8+7) carries the tag of window slot k.
- R2: A slot whose first or second source equals the destination of an older valid slot in the same window does not issue. This applies only when that older slot has its write-enable set.
- R3: Issue is strictly in order. `iss_cnt_o` is the index of the first blocked slot, and `iss_mask_o` has bits 0 up to `iss_cnt_o`-1 set and no others. A younger independent slot never issues past a held one.
- R4: Register index 0 never creates a dependence. A destination whose write-enable is low never creates a dependence either.
- R5: At most one slot marked as a memory access (load or store) issues per cycle. A second one in the window is held.
- R6: At most one slot marked as a divider user issues per cycle. A second one in the window is held.
- R7: A slot that reads the destination of a load issued in the previous cycle is blocked for that cycle. If one idle cycle lies between the load and the reader, the reader is not blocked.
- R8: Slots that do not issue are moved to the front of the window and presented again in the next cycle. While any held slot remains, `in_ready_o` is low and the input group is ignored.
- R9: `stall_o` is high exactly when the current window has valid slots that do not issue this cycle.
- R10: While `flush_i` is high, nothing issues, `stall_o` and `in_ready_o` are low, and all held slots and pending-load state are cleared. In the next cycle the block is empty.
- R11: After reset the window is empty, `in_ready_o` is high, and `iss_cnt_o`, `iss_mask_o` and `stall_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush_i | input | 1 | Synchronous flush of held slots and load state |
| in_valid_i | input | WIDTH | Slot valid bits of the offered group, slot 0 oldest |
| in_src1_i | input | WIDTH*5 | First source register per slot |
| in_src2_i | input | WIDTH*5 | Second source register per slot |
| in_dst_i | input | WIDTH*5 | Destination register per slot |
| in_wen_i | input | WIDTH | Destination write-enable per slot |
| in_load_i | input | WIDTH | Slot is a load (also set in_mem_i) |
| in_mem_i | input | WIDTH | Slot uses the memory port |
| in_div_i | input | WIDTH | Slot uses the divider |
| in_tag_i | input | WIDTH*8 | Opaque tag per slot |
| in_ready_o | output | 1 | Offered group is taken this cycle |
| iss_mask_o | output | WIDTH | Window slots that issue this cycle |
| iss_cnt_o | output | $clog2(WIDTH+1) | Number of slots issuing |
| iss_tag_o | output | WIDTH*8 | Tags of the window slots, lane k = slot k |
| stall_o | output | 1 | Valid slots of the window are held |

## Verification
Two hazards can meet in one cycle: a load-use block on the oldest slot of a new group, and that group arriving right after the load's group drained. The first effect gives a zero-count stall cycle. The bench then expects the whole group to come back from the hold buffer one cycle later with every tag in its original lane. The second pairing is a flush arriving while a held remainder and a pending load both exist. It is judged by a silent flush cycle, an empty block one cycle after it, and a following reader of the load's register issuing at full width.

// File: rtl/iss_pkg.sv
// Shared slot type and helpers for the in-order issue gate.
// Assumes small register indices and a fixed-width opaque tag per slot.
package iss_pkg;

    localparam int unsigned REG_W = 5;
    localparam int unsigned TAG_W = 8;

    typedef struct packed {
        logic             valid;
        logic [REG_W-1:0] src1;
        logic [REG_W-1:0] src2;
        logic [REG_W-1:0] dst;
        logic             wen;
        logic             load;
        logic             mem;
        logic             div;
        logic [TAG_W-1:0] tag;
    } slot_t;

    // True when a slot reads register r; register 0 is never a real read.
    function automatic logic slot_reads(slot_t s, logic [REG_W-1:0] r);
        return (r != '0) && ((s.src1 == r) || (s.src2 == r));
    endfunction

    // True when a slot produces a value that a younger slot could depend on.
    function automatic logic slot_writes(slot_t s);
        return s.valid && s.wen && (s.dst != '0);
    endfunction

endpackage

// File: rtl/iss_hazard.sv
// Per-slot blocking conditions for the issue window.
// Each slot is checked against every older slot (RAW, memory port,
// divider) and against the load that issued in the previous cycle.
// Assumes slot 0 is the oldest instruction.
module iss_hazard
    import iss_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  slot_t [WIDTH-1:0] win_i,
    input  logic              pend_vld_i,
    input  logic [REG_W-1:0]  pend_dst_i,
    output logic [WIDTH-1:0]  blocked_o
);

    for (genvar j = 0; j < WIDTH; j++) begin : g_slot
        logic raw_hit;
        logic mem_hit;
        logic div_hit;
        logic ld_use;

        // Gather the conditions that keep slot j from leaving this cycle.
        always_comb begin
            raw_hit = 1'b0;
            mem_hit = 1'b0;
            div_hit = 1'b0;
            for (int i = 0; i < j; i++) begin
                if (slot_writes(win_i[i]) && slot_reads(win_i[j], win_i[i].dst))
                    raw_hit = 1'b1;
                if (win_i[i].valid && win_i[i].mem && win_i[j].mem)
                    mem_hit = 1'b1;
                if (win_i[i].valid && win_i[i].div && win_i[j].div)
                    div_hit = 1'b1;
            end
            ld_use = pend_vld_i && slot_reads(win_i[j], pend_dst_i);
        end

        assign blocked_o[j] = !win_i[j].valid || raw_hit || mem_hit || div_hit || ld_use;
    end

endmodule

// File: rtl/iss_select.sv
// Turns per-slot blocking flags into an in-order issue prefix.
// The first blocked slot ends the prefix; kill_i suppresses all issue.
module iss_select #(
    parameter  int unsigned WIDTH = 4,
    localparam int unsigned CW    = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] blocked_i,
    input  logic             kill_i,
    output logic [WIDTH-1:0] mask_o,
    output logic [CW-1:0]    cnt_o
);

    // Walk slots oldest first, stop at the first blocked one, count issues.
    always_comb begin
        logic run;
        run    = !kill_i;
        cnt_o  = '0;
        mask_o = '0;
        for (int k = 0; k < WIDTH; k++) begin
            run       = run && !blocked_i[k];
            mask_o[k] = run;
            if (run)
                cnt_o = cnt_o + CW'(1);
        end
    end

endmodule

// File: rtl/iss_holdbuf.sv
// Holds the slots that did not issue, moved down to the front.
// Assumes the issued slots form a prefix of length cnt_i.
module iss_holdbuf
    import iss_pkg::*;
#(
    parameter  int unsigned WIDTH = 4,
    localparam int unsigned CW    = $clog2(WIDTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  slot_t [WIDTH-1:0] win_i,
    input  logic [CW-1:0]     cnt_i,
    output slot_t [WIDTH-1:0] held_o,
    output logic              held_any_o
);

    slot_t [WIDTH-1:0] held_q;
    slot_t [WIDTH-1:0] shifted;

    // Move slot k+cnt into position k; positions past the end become empty.
    always_comb begin
        shifted = '0;
        for (int k = 0; k < WIDTH; k++) begin
            for (int s = 0; s < WIDTH; s++) begin
                if (s == k + int'(cnt_i))
                    shifted[k] = win_i[s];
            end
        end
    end

    // Register the remainder; reset and flush empty the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (flush_i)
            held_q <= '0;
        else
            held_q <= shifted;
    end

    // Report whether any slot is waiting.
    always_comb begin
        held_any_o = 1'b0;
        for (int k = 0; k < WIDTH; k++)
            held_any_o = held_any_o | held_q[k].valid;
    end

    assign held_o = held_q;

    AST_FLUSH_EMPTIES_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !held_any_o); // R10

endmodule

// File: rtl/iss_loadtrk.sv
// Remembers the destination of a load issued this cycle for one cycle.
// Assumes at most one load issues per cycle (single memory port).
module iss_loadtrk
    import iss_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  slot_t [WIDTH-1:0] win_i,
    input  logic [WIDTH-1:0]  mask_i,
    output logic              pend_vld_o,
    output logic [REG_W-1:0]  pend_dst_o
);

    logic             nxt_vld;
    logic [REG_W-1:0] nxt_dst;

    // Find an issuing load that writes a real register.
    always_comb begin
        nxt_vld = 1'b0;
        nxt_dst = '0;
        for (int k = 0; k < WIDTH; k++) begin
            if (mask_i[k] && win_i[k].load && slot_writes(win_i[k])) begin
                nxt_vld = 1'b1;
                nxt_dst = win_i[k].dst;
            end
        end
    end

    // Keep it for exactly the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            pend_vld_o <= 1'b0;
            pend_dst_o <= '0;
        end else begin
            pend_vld_o <= nxt_vld;
            pend_dst_o <= nxt_dst;
        end
    end

    AST_LOAD_PEND_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vld_o |-> (pend_dst_o != '0)); // R4

endmodule

// File: rtl/iss_gate.sv
// In-order issue gate for a WIDTH-wide decode stage.
// The window is the held remainder if any, else the offered group.
// Issues the longest hazard-free prefix and holds the rest.
// Assumes offered valid bits are contiguous from slot 0.
module iss_gate
    import iss_pkg::*;
#(
    parameter  int unsigned WIDTH = 4,
    localparam int unsigned CW    = $clog2(WIDTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush_i,
    input  logic [WIDTH-1:0]         in_valid_i,
    input  logic [WIDTH*REG_W-1:0]   in_src1_i,
    input  logic [WIDTH*REG_W-1:0]   in_src2_i,
    input  logic [WIDTH*REG_W-1:0]   in_dst_i,
    input  logic [WIDTH-1:0]         in_wen_i,
    input  logic [WIDTH-1:0]         in_load_i,
    input  logic [WIDTH-1:0]         in_mem_i,
    input  logic [WIDTH-1:0]         in_div_i,
    input  logic [WIDTH*TAG_W-1:0]   in_tag_i,
    output logic                     in_ready_o,
    output logic [WIDTH-1:0]         iss_mask_o,
    output logic [CW-1:0]            iss_cnt_o,
    output logic [WIDTH*TAG_W-1:0]   iss_tag_o,
    output logic                     stall_o
);

    slot_t [WIDTH-1:0] in_win;
    slot_t [WIDTH-1:0] held;
    slot_t [WIDTH-1:0] win;
    logic              held_any;
    logic [WIDTH-1:0]  blocked;
    logic              pend_vld;
    logic [REG_W-1:0]  pend_dst;
    logic [WIDTH-1:0]  win_valid;
    logic [WIDTH-1:0]  win_mem;
    logic [WIDTH-1:0]  win_div;

    // Unpack the offered group into slot records.
    always_comb begin
        for (int k = 0; k < WIDTH; k++) begin
            in_win[k].valid = in_valid_i[k];
            in_win[k].src1  = in_src1_i[k*REG_W +: REG_W];
            in_win[k].src2  = in_src2_i[k*REG_W +: REG_W];
            in_win[k].dst   = in_dst_i[k*REG_W +: REG_W];
            in_win[k].wen   = in_wen_i[k];
            in_win[k].load  = in_load_i[k];
            in_win[k].mem   = in_mem_i[k];
            in_win[k].div   = in_div_i[k];
            in_win[k].tag   = in_tag_i[k*TAG_W +: TAG_W];
        end
    end

    // Held slots take precedence over a new group.
    assign win = held_any ? held : in_win;

    // Flatten window fields for outputs and checks.
    always_comb begin
        for (int k = 0; k < WIDTH; k++) begin
            win_valid[k]              = win[k].valid;
            win_mem[k]                = win[k].mem;
            win_div[k]                = win[k].div;
            iss_tag_o[k*TAG_W +: TAG_W] = win[k].tag;
        end
    end

    iss_hazard #(.WIDTH(WIDTH)) u_hazard (
        .win_i      (win),
        .pend_vld_i (pend_vld),
        .pend_dst_i (pend_dst),
        .blocked_o  (blocked)
    );

    iss_select #(.WIDTH(WIDTH)) u_select (
        .blocked_i (blocked),
        .kill_i    (flush_i),
        .mask_o    (iss_mask_o),
        .cnt_o     (iss_cnt_o)
    );

    iss_holdbuf #(.WIDTH(WIDTH)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .win_i      (win),
        .cnt_i      (iss_cnt_o),
        .held_o     (held),
        .held_any_o (held_any)
    );

    iss_loadtrk #(.WIDTH(WIDTH)) u_ldtrk (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .win_i      (win),
        .mask_i     (iss_mask_o),
        .pend_vld_o (pend_vld),
        .pend_dst_o (pend_dst)
    );

    // Accept a group only when nothing is waiting and no flush is active.
    assign in_ready_o = !held_any && !flush_i;

    // Report valid slots that stay behind this cycle.
    assign stall_o = !flush_i && ((win_valid & ~iss_mask_o) != '0);

    AST_ONE_MEM_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(iss_mask_o & win_mem) <= 1); // R5

    AST_ONE_DIV_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(iss_mask_o & win_div) <= 1); // R6

    AST_ISSUE_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        ((iss_mask_o + WIDTH'(1)) & iss_mask_o) == '0); // R3

    AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> (iss_mask_o == '0) && !stall_o && !in_ready_o); // R10

    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> !in_ready_o); // R8

    for (genvar j = 1; j < WIDTH; j++) begin : g_chk_raw
        for (genvar i = 0; i < j; i++) begin : g_old
            AST_NO_RAW_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
                !(iss_mask_o[j] && slot_writes(win[i]) && slot_reads(win[j], win[i].dst))); // R2
        end
    end

    for (genvar k = 0; k < WIDTH; k++) begin : g_chk_lu
        AST_NO_LOAD_USE: assert property (@(posedge clk) disable iff (!rst_n)
            !(iss_mask_o[k] && pend_vld && slot_reads(win[k], pend_dst))); // R7
    end

endmodule

// File: tb/iss_gate_tb.sv
// Scoreboard bench: scenario tasks queue the expected issue of every busy
// cycle, a negedge monitor compares the issue outputs against the queue.
module iss_gate_tb;

    localparam int W  = 4;
    localparam int RW = 5;
    localparam int TW = 8;
    localparam int CW = $clog2(W + 1);

    typedef struct {
        int          cnt;
        logic [31:0] tags;
        bit          stall;
        string       req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush_i = 1'b0;
    logic [W-1:0]      in_valid = '0;
    logic [W*RW-1:0]   in_src1 = '0;
    logic [W*RW-1:0]   in_src2 = '0;
    logic [W*RW-1:0]   in_dst = '0;
    logic [W-1:0]      in_wen = '0;
    logic [W-1:0]      in_load = '0;
    logic [W-1:0]      in_mem = '0;
    logic [W-1:0]      in_div = '0;
    logic [W*TW-1:0]   in_tag = '0;
    logic              in_ready_o;
    logic [W-1:0]      iss_mask_o;
    logic [CW-1:0]     iss_cnt_o;
    logic [W*TW-1:0]   iss_tag_o;
    logic              stall_o;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    iss_gate #(.WIDTH(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_i    (flush_i),
        .in_valid_i (in_valid),
        .in_src1_i  (in_src1),
        .in_src2_i  (in_src2),
        .in_dst_i   (in_dst),
        .in_wen_i   (in_wen),
        .in_load_i  (in_load),
        .in_mem_i   (in_mem),
        .in_div_i   (in_div),
        .in_tag_i   (in_tag),
        .in_ready_o (in_ready_o),
        .iss_mask_o (iss_mask_o),
        .iss_cnt_o  (iss_cnt_o),
        .iss_tag_o  (iss_tag_o),
        .stall_o    (stall_o)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] tg(int t0, int t1, int t2, int t3);
        return {8'(t3), 8'(t2), 8'(t1), 8'(t0)};
    endfunction

    task automatic expect_c(int c, logic [31:0] tags, bit st, string req);
        exp_t e;
        e.cnt = c; e.tags = tags; e.stall = st; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic put(int k, int s1, int s2, int d, bit wen, bit ld, bit mem, bit dv, int tag);
        in_valid[k]           = 1'b1;
        in_src1[k*RW +: RW]   = RW'(s1);
        in_src2[k*RW +: RW]   = RW'(s2);
        in_dst[k*RW +: RW]    = RW'(d);
        in_wen[k]             = wen;
        in_load[k]            = ld;
        in_mem[k]             = mem;
        in_div[k]             = dv;
        in_tag[k*TW +: TW]    = TW'(tag);
    endtask

    // Offer the group until taken, then withdraw it right after the edge.
    task automatic fire();
        do @(negedge clk); while (!in_ready_o);
        @(posedge clk);
        #1;
        in_valid = '0; in_load = '0; in_mem = '0; in_div = '0; in_wen = '0;
    endtask

    // Monitor: every cycle with issue or stall consumes one expected record.
    always @(negedge clk) begin
        if (rst_n && (iss_cnt_o != '0 || stall_o)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "unexpected issue", int'(iss_cnt_o), 0);
            end else begin
                exp_t e;
                logic [31:0] am;
                e  = exp_q.pop_front();
                am = '0;
                for (int k = 0; k < W; k++)
                    if (k < e.cnt) am[k*TW +: TW] = 8'hFF;
                chk(int'(iss_cnt_o) == e.cnt, {e.req, " count"}, int'(iss_cnt_o), e.cnt);
                chk(stall_o == e.stall, {e.req, " stall (R9)"}, int'(stall_o), int'(e.stall));
                chk((iss_tag_o & am) == (e.tags & am), {e.req, " tags"}, int'(iss_tag_o & am), int'(e.tags & am));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(in_ready_o == 1'b1, "R11 ready", int'(in_ready_o), 1);
        chk(iss_cnt_o == '0 && iss_mask_o == '0, "R11 no issue", int'(iss_cnt_o), 0);
        chk(stall_o == 1'b0, "R11 stall", int'(stall_o), 0);
        @(posedge clk); #1;

        // R1 independent full group
        put(0, 1, 2, 3, 1, 0, 0, 0, 'h10);
        put(1, 4, 5, 6, 1, 0, 0, 0, 'h11);
        put(2, 7, 8, 9, 1, 0, 0, 0, 'h12);
        put(3, 10, 11, 12, 1, 0, 0, 0, 'h13);
        expect_c(4, tg('h10, 'h11, 'h12, 'h13), 0, "R1 full group");
        fire();

        // R2 RAW on slot 1, R3 younger independent slots wait, R8 shift
        put(0, 1, 2, 3, 1, 0, 0, 0, 'h20);
        put(1, 3, 4, 6, 1, 0, 0, 0, 'h21);
        put(2, 7, 8, 9, 1, 0, 0, 0, 'h22);
        put(3, 10, 11, 12, 1, 0, 0, 0, 'h23);
        expect_c(1, tg('h20, 0, 0, 0), 1, "R2 R3 raw holds younger");
        expect_c(3, tg('h21, 'h22, 'h23, 0), 0, "R8 held shifted to front");
        fire();
        @(negedge clk);
        chk(in_ready_o == 1'b0, "R8 ready low while held", int'(in_ready_o), 0);
        @(posedge clk); #1;

        // R2 via second source on the last slot against the oldest slot
        put(0, 1, 2, 13, 1, 0, 0, 0, 'h30);
        put(1, 4, 5, 14, 1, 0, 0, 0, 'h31);
        put(2, 7, 8, 15, 1, 0, 0, 0, 'h32);
        put(3, 9, 13, 16, 1, 0, 0, 0, 'h33);
        expect_c(3, tg('h30, 'h31, 'h32, 0), 1, "R2 src2 vs slot0");
        expect_c(1, tg('h33, 0, 0, 0), 0, "R8 last slot alone");
        fire();

        // R4 register 0 and write-enable off
        put(0, 1, 2, 0, 1, 0, 0, 0, 'h40);
        put(1, 0, 0, 5, 1, 0, 0, 0, 'h41);
        put(2, 3, 4, 7, 0, 0, 0, 0, 'h42);
        put(3, 7, 7, 8, 1, 0, 0, 0, 'h43);
        expect_c(4, tg('h40, 'h41, 'h42, 'h43), 0, "R4 no false dependence");
        fire();

        // R5 two memory accesses
        put(0, 1, 2, 0, 0, 0, 1, 0, 'h50);
        put(1, 3, 4, 5, 1, 0, 0, 0, 'h51);
        put(2, 6, 7, 0, 0, 0, 1, 0, 'h52);
        put(3, 8, 9, 10, 1, 0, 0, 0, 'h53);
        expect_c(2, tg('h50, 'h51, 0, 0), 1, "R5 second memory held");
        expect_c(2, tg('h52, 'h53, 0, 0), 0, "R5 remainder");
        fire();

        // R6 two divider users
        put(0, 1, 2, 3, 1, 0, 0, 1, 'h60);
        put(1, 4, 5, 6, 1, 0, 0, 1, 'h61);
        put(2, 7, 8, 9, 1, 0, 0, 0, 'h62);
        put(3, 10, 11, 12, 1, 0, 0, 0, 'h63);
        expect_c(1, tg('h60, 0, 0, 0), 1, "R6 second divider held");
        expect_c(3, tg('h61, 'h62, 'h63, 0), 0, "R6 remainder");
        fire();

        // R7 load then immediate reader
        put(0, 1, 2, 10, 1, 1, 1, 0, 'h70);
        put(1, 3, 4, 11, 1, 0, 0, 0, 'h71);
        expect_c(2, tg('h70, 'h71, 0, 0), 0, "R7 load group");
        fire();
        put(0, 10, 1, 12, 1, 0, 0, 0, 'h80);
        put(1, 2, 3, 13, 1, 0, 0, 0, 'h81);
        put(2, 4, 5, 14, 1, 0, 0, 0, 'h82);
        put(3, 6, 7, 15, 1, 0, 0, 0, 'h83);
        expect_c(0, tg(0, 0, 0, 0), 1, "R7 load-use bubble");
        expect_c(4, tg('h80, 'h81, 'h82, 'h83), 0, "R7 R8 reader replayed");
        fire();

        // R7 one idle cycle between load and reader removes the block
        put(0, 1, 2, 14, 1, 1, 1, 0, 'h90);
        expect_c(1, tg('h90, 0, 0, 0), 0, "R7 lone load");
        fire();
        @(posedge clk); #1;
        put(0, 14, 0, 15, 1, 0, 0, 0, 'hA0);
        put(1, 1, 14, 16, 1, 0, 0, 0, 'hA1);
        put(2, 2, 3, 17, 1, 0, 0, 0, 'hA2);
        put(3, 4, 5, 18, 1, 0, 0, 0, 'hA3);
        expect_c(4, tg('hA0, 'hA1, 'hA2, 'hA3), 0, "R7 delay expired");
        fire();

        // R10 flush with held remainder and pending load
        put(0, 1, 2, 20, 1, 1, 1, 0, 'hB0);
        put(1, 20, 3, 21, 1, 0, 0, 0, 'hB1);
        put(2, 4, 5, 22, 1, 0, 0, 0, 'hB2);
        put(3, 6, 7, 23, 1, 0, 0, 0, 'hB3);
        expect_c(1, tg('hB0, 0, 0, 0), 1, "R10 setup");
        fire();
        flush_i = 1'b1;
        @(negedge clk);
        chk(iss_cnt_o == '0 && iss_mask_o == '0, "R10 no issue in flush", int'(iss_cnt_o), 0);
        chk(in_ready_o == 1'b0 && stall_o == 1'b0, "R10 quiet flush", int'({in_ready_o, stall_o}), 0);
        @(posedge clk); #1;
        flush_i = 1'b0;
        @(negedge clk);
        chk(in_ready_o == 1'b1 && stall_o == 1'b0 && iss_cnt_o == '0, "R10 empty after flush",
            int'({in_ready_o, stall_o}), 2);
        @(posedge clk); #1;
        put(0, 20, 21, 24, 1, 0, 0, 0, 'hC0);
        put(1, 1, 20, 25, 1, 0, 0, 0, 'hC1);
        put(2, 2, 3, 26, 1, 0, 0, 0, 'hC2);
        put(3, 4, 5, 27, 1, 0, 0, 0, 'hC3);
        expect_c(4, tg('hC0, 'hC1, 'hC2, 'hC3), 0, "R10 clean after flush");
        fire();

        repeat (6) @(posedge clk);
        chk(exp_q.size() == 0, "scoreboard drained (R3)", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule